// File: doc/BRIEF.md
# Locked Index/Data Configuration Port

This block is a configuration window for a multi-function I/O controller. A byte-wide host bus reaches it at two adjacent addresses. The lower address (`bus_addr` = 0) holds a register index, and the upper one (`bus_addr` = 1) carries the data of the indexed register. Software writes the index first, then reads or writes the data address. The window starts closed. Until a fixed two-byte unlock code has been written to the index address, the data address reads as all ones and ignores writes.

Once the window is open, a few global registers report a fixed identity and the strap that picks the port's base address. A select register chooses one of `NUM_LD` logical devices. Index 0x30 is that device's enable bit, which is held inside this block and driven out on `ld_active`. Indices above 0x30 are passed through to the selected device as a one-hot strobe together with the index, the write data and a read-back bus. Writing the exit code to the index address closes the window again.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is closed. Reads of either address return 0xFF, and `ld_active` is all zero.
- R2: While the window is closed, data-address writes change no register. No device strobe (`ld_sel`, `ld_wr`, `ld_rd`) is raised, and `ld_active` holds.
- R3: Two consecutive index-address writes of 0x87 open the window. When open, a read of the index address returns the last index written.
- R4: Any index-address write other than 0x87 between the two unlock bytes restarts the unlock sequence. So 0x87, 0x12, 0x87 leaves the window closed, and one more 0x87 then opens it.
- R5: An index-address write of 0xAA while open closes the window. The next data reads return 0xFF, and data writes are ignored.
- R6: Index 0x20 reads the device identity parameter and index 0x21 reads the revision parameter.
- R7: Index 0x26 reads the `strap_hi` input in bit 6, with all other bits 0. A strap of 0 selects base 0x2E and a strap of 1 selects base 0x4E.
- R8: Index 0x07 is the logical-device select. It is written and read back as a full byte.
- R9: Index 0x30 is the enable bit of the selected device. Bit 0 of the written data is stored, bit 0 reads back with bits 7:1 as 0, and the stored bits drive `ld_active[n]` for device n.
- R10: A data access to an index above 0x30 with select n < `NUM_LD` raises `ld_sel[n]` alone, together with `ld_wr` or `ld_rd` for that bus cycle. It presents the index on `ld_idx` and the write byte on `ld_wdata`. A read returns `ld_rdata[8n+7:8n]`.
- R11: With a select value of `NUM_LD` or above, device-range accesses raise no strobe and read 0x00. Writes to index 0x30 leave `ld_active` unchanged.
- R12: Global indices that are not implemented read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 selects the index address, 1 selects the data address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| strap_hi | input | 1 | Base-address strap level |
| ld_sel | output | NUM_LD | One-hot select of the addressed logical device |
| ld_wr | output | 1 | Device register write strobe |
| ld_rd | output | 1 | Device register read strobe |
| ld_idx | output | 8 | Device register index |
| ld_wdata | output | 8 | Device register write byte |
| ld_rdata | input | 8*NUM_LD | Read-back bytes, device n in bits 8n+7:8n |
| ld_active | output | NUM_LD | Enable bit of each logical device |

## Verification
The bench builds the port with four logical devices, identity 0xC1 and revision 0x07. Four devices are enough to show that the one-hot select lands on the right bit and that read-back comes from the right byte lane. A select value of 7 then takes the block past the last device, so the out-of-range path can be checked. The strap input is driven both ways, and the unlock sequence is exercised both cleanly and with an interrupting byte.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int          NUM_LD  = 4,
  parameter logic [7:0]  DEV_ID  = 8'hA5,
  parameter logic [7:0]  DEV_REV = 8'h01,
  parameter logic [7:0]  UNLOCK  = 8'h87,
  parameter logic [7:0]  EXIT    = 8'hAA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic                 strap_hi,
  output logic [NUM_LD-1:0]    ld_sel,
  output logic                 ld_wr,
  output logic                 ld_rd,
  output logic [7:0]           ld_idx,
  output logic [7:0]           ld_wdata,
  input  logic [8*NUM_LD-1:0]  ld_rdata,
  output logic [NUM_LD-1:0]    ld_active
);

  localparam int         SEL_W     = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;
  localparam logic [7:0] LD_CNT    = 8'(NUM_LD);
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ID    = 8'h20;
  localparam logic [7:0] IDX_REV   = 8'h21;
  localparam logic [7:0] IDX_STRAP = 8'h26;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [1:0] ST_LOCK   = 2'd0;
  localparam logic [1:0] ST_ARMED  = 2'd1;
  localparam logic [1:0] ST_OPEN   = 2'd2;

  logic [1:0]        st_q;
  logic [7:0]        idx_q;
  logic [7:0]        ldn_q;
  logic [NUM_LD-1:0] act_q;

  wire              idx_wr  = bus_wr & ~bus_addr;
  wire              data_wr = bus_wr & bus_addr;
  wire              data_rd = bus_rd & bus_addr;
  wire              is_open = (st_q == ST_OPEN);
  wire              ldn_ok  = (ldn_q < LD_CNT);
  wire              ld_zone = (idx_q > IDX_ACT);
  wire              fwd     = is_open & ldn_ok & ld_zone;
  wire [SEL_W-1:0]  ldn_sel = ldn_q[SEL_W-1:0];
  wire [7:0]        dev_rd  = ld_rdata[{ldn_sel, 3'b000} +: 8];

  assign ld_wr     = fwd & data_wr;
  assign ld_rd     = fwd & data_rd;
  assign ld_idx    = idx_q;
  assign ld_wdata  = bus_wdata;
  assign ld_active = act_q;

  for (genvar g = 0; g < NUM_LD; g++) begin : g_sel
    assign ld_sel[g] = (ld_wr | ld_rd) & (ldn_q == 8'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_LOCK;
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
      act_q <= '0;
    end else begin
      if (idx_wr) begin
        case (st_q)
          ST_LOCK:  st_q <= (bus_wdata == UNLOCK) ? ST_ARMED : ST_LOCK;
          ST_ARMED: st_q <= (bus_wdata == UNLOCK) ? ST_OPEN : ST_LOCK;
          default:
            if (bus_wdata == EXIT) st_q <= ST_LOCK;
            else                   idx_q <= bus_wdata;
        endcase
      end
      if (data_wr && is_open) begin
        if (idx_q == IDX_LDN) ldn_q <= bus_wdata;
        if (idx_q == IDX_ACT && ldn_ok) act_q[ldn_sel] <= bus_wdata[0];
      end
    end
  end

  always_comb begin
    bus_rdata = 8'hFF;
    if (is_open) begin
      if (!bus_addr) bus_rdata = idx_q;
      else begin
        case (idx_q)
          IDX_LDN:   bus_rdata = ldn_q;
          IDX_ID:    bus_rdata = DEV_ID;
          IDX_REV:   bus_rdata = DEV_REV;
          IDX_STRAP: bus_rdata = {1'b0, strap_hi, 6'b0};
          IDX_ACT:   bus_rdata = ldn_ok ? {7'b0, act_q[ldn_sel]} : 8'h00;
          default:   bus_rdata = (ld_zone && ldn_ok) ? dev_rd : 8'h00;
        endcase
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int         NUM_LD = 4,
  parameter logic [7:0] UNLOCK = 8'h87,
  parameter logic [7:0] EXIT   = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [NUM_LD-1:0] ld_sel,
  input logic              ld_wr,
  input logic              ld_rd,
  input logic [NUM_LD-1:0] ld_active,
  input logic [1:0]        st_q
);

  AST_CLOSED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 2'd2) |-> (bus_rdata == 8'hFF)); // R1

  AST_CLOSED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 2'd2) |-> (ld_sel == '0 && !ld_wr && !ld_rd)); // R2

  AST_CLOSED_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 2'd2) |=> $stable(ld_active)); // R2

  AST_SECOND_CODE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd1 && bus_wr && !bus_addr && bus_wdata == UNLOCK) |=> (st_q == 2'd2)); // R3

  AST_STRAY_BYTE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd1 && bus_wr && !bus_addr && bus_wdata != UNLOCK) |=> (st_q == 2'd0)); // R4

  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd2 && bus_wr && !bus_addr && bus_wdata == EXIT) |=> (st_q == 2'd0)); // R5

  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_sel)); // R10

  AST_WR_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |-> (bus_wr && bus_addr && ld_sel != '0)); // R10

  AST_RD_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rd |-> (bus_rd && bus_addr && ld_sel != '0)); // R10

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_LD(NUM_LD), .UNLOCK(UNLOCK), .EXIT(EXIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ld_sel(ld_sel), .ld_wr(ld_wr),
  .ld_rd(ld_rd), .ld_active(ld_active), .st_q(st_q)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam int NLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic strap_hi = 1'b0;
  logic [NLD-1:0] ld_sel, ld_active;
  logic ld_wr, ld_rd;
  logic [7:0] ld_idx, ld_wdata;
  logic [8*NLD-1:0] ld_rdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0;
  logic [NLD-1:0] last_sel = '0;
  logic [7:0] last_idx = 8'h00, last_data = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;

  for (genvar k = 0; k < NLD; k++) begin : g_dev
    assign ld_rdata[k*8 +: 8] = {4'(k + 1), ld_idx[3:0]};
  end

  always @(posedge clk) if (ld_wr) begin
    wr_cnt    <= wr_cnt + 1;
    last_sel  <= ld_sel;
    last_idx  <= ld_idx;
    last_data <= ld_wdata;
  end

  sio_cfg_port #(.NUM_LD(NLD), .DEV_ID(8'hC1), .DEV_REV(8'h07)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_hi(strap_hi),
    .ld_sel(ld_sel), .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_idx(ld_idx),
    .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .ld_active(ld_active)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d, output logic [NLD-1:0] s);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2;
    d = bus_rdata; s = ld_sel;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] i, output logic [7:0] d);
    logic [NLD-1:0] s;
    wr(1'b0, i);
    rd(1'b1, d, s);
  endtask

  task automatic reg_wr(logic [7:0] i, logic [7:0] d);
    wr(1'b0, i);
    wr(1'b1, d);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [NLD-1:0] s;
    rd(1'b1, d, s); chk("R1 data read closed", d, 8'hFF);
    rd(1'b0, d, s); chk("R1 index read closed", d, 8'hFF);
    chk("R1 active after reset", 8'(ld_active), 8'h00);
  endtask

  task automatic t_closed_writes();
    logic [7:0] d; logic [NLD-1:0] s;
    wr(1'b0, 8'h07); wr(1'b1, 8'h02);
    wr(1'b0, 8'h45); wr(1'b1, 8'h33);
    rd(1'b1, d, s);
    chk("R2 closed strobe count", 8'(wr_cnt), 8'd0);
    chk("R2 closed read strobe", 8'(s), 8'h00);
    chk("R2 closed active", 8'(ld_active), 8'h00);
  endtask

  task automatic t_unlock_restart();
    logic [7:0] d; logic [NLD-1:0] s;
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    rd(1'b1, d, s); chk("R4 interrupted sequence stays closed", d, 8'hFF);
    wr(1'b0, 8'h87);
    rd(1'b0, d, s); chk("R3 open index read", d, 8'h00);
    wr(1'b0, 8'h07);
    rd(1'b0, d, s); chk("R3 index read back", d, 8'h07);
    rd(1'b1, d, s); chk("R2 closed write did not reach select", d, 8'h00);
  endtask

  task automatic t_globals();
    logic [7:0] d;
    reg_rd(8'h20, d); chk("R6 identity", d, 8'hC1);
    reg_rd(8'h21, d); chk("R6 revision", d, 8'h07);
    strap_hi = 1'b1;
    reg_rd(8'h26, d); chk("R7 strap high", d, 8'h40);
    strap_hi = 1'b0;
    reg_rd(8'h26, d); chk("R7 strap low", d, 8'h00);
    reg_wr(8'h22, 8'h5C);
    reg_rd(8'h22, d); chk("R12 unimplemented global", d, 8'h00);
    chk("R12 no strobe", 8'(wr_cnt), 8'd0);
  endtask

  task automatic t_select_activate();
    logic [7:0] d;
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h07, d); chk("R8 select read back", d, 8'h02);
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, d); chk("R9 enable reads bit 0 only", d, 8'h01);
    chk("R9 active device 2", 8'(ld_active), 8'h04);
    reg_wr(8'h07, 8'h01);
    reg_rd(8'h30, d); chk("R9 device 1 still off", d, 8'h00);
    reg_wr(8'h30, 8'h01);
    chk("R9 active devices 1 and 2", 8'(ld_active), 8'h06);
    reg_wr(8'h30, 8'hFE);
    chk("R9 bit 0 clears device 1", 8'(ld_active), 8'h04);
  endtask

  task automatic t_forward();
    logic [7:0] d; logic [NLD-1:0] s;
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h45, 8'h5A);
    chk("R10 write count", 8'(wr_cnt), 8'd1);
    chk("R10 write select", 8'(last_sel), 8'h02);
    chk("R10 write index", last_idx, 8'h45);
    chk("R10 write data", last_data, 8'h5A);
    rd(1'b1, d, s);
    chk("R10 read lane device 1", d, 8'h25);
    chk("R10 read select", 8'(s), 8'h02);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'hF7, d); chk("R10 read lane device 3", d, 8'h47);
  endtask

  task automatic t_out_of_range();
    logic [7:0] d; logic [NLD-1:0] s;
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h07, d); chk("R8 select value 7", d, 8'h07);
    reg_wr(8'h45, 8'h11);
    chk("R11 no write strobe", 8'(wr_cnt), 8'd1);
    rd(1'b1, d, s);
    chk("R11 device read zero", d, 8'h00);
    chk("R11 no read select", 8'(s), 8'h00);
    reg_wr(8'h30, 8'h01);
    chk("R11 active unchanged", 8'(ld_active), 8'h04);
    reg_rd(8'h30, d); chk("R11 enable read zero", d, 8'h00);
  endtask

  task automatic t_exit();
    logic [7:0] d; logic [NLD-1:0] s;
    reg_wr(8'h07, 8'h02);
    wr(1'b0, 8'hAA);
    rd(1'b1, d, s); chk("R5 closed after exit", d, 8'hFF);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    reg_rd(8'h07, d); chk("R5 closed write ignored", d, 8'h02);
    chk("R5 active kept", 8'(ld_active), 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_closed_writes();
    t_unlock_restart();
    t_globals();
    t_select_activate();
    t_forward();
    t_out_of_range();
    t_exit();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule